// File: doc/BRIEF.md
# Rank-Counter LRU Victim Tracker

This block tracks true least-recently-used order for a single set of a set-associative cache. Each way owns a small rank register. A rank of zero marks the way that has gone longest without use, and the top rank marks the way used most recently. The cache controller reports every hit or fill by strobing an access with the way index. When it needs a line to evict, it reads the victim index, which is always available from the current ranks.

An access promotes the touched way to the top rank. Only the ways that ranked above the touched way's previous rank move down by one step. The other ways keep their ranks. After reset the ranks form a permutation, and this update keeps them a permutation, so the victim is unique at all times. The way count is a parameter and defaults to four.

Top module: `lru_rank_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, way i is loaded with rank i. After reset, the victim index is 0 and the order from oldest to newest is way 0, 1, ..., WAYS-1.
- R2: After a clock edge with `acc_valid` high, the way named by `acc_way` holds the top rank, WAYS-1. That way becomes the last candidate for eviction.
- R3: On an access, each other way whose rank was above the accessed way's old rank drops by exactly one. Each other way whose rank was below it keeps its rank.
- R4: `victim_way` is combinational and always gives the index of the way whose rank is 0.
- R5: Accessing the way that already holds the top rank leaves every rank unchanged.
- R6: After any sequence of accesses, the ranks are a permutation of 0..WAYS-1, so exactly one way holds rank 0.
- R7: When an access and a replace request share a cycle, `victim_way` shows the order from before that access. The new order appears after the clock edge.
- R8: `repl_req` does not alter the ranks. `victim_valid` is high in exactly the cycles where `repl_req` is high.
- R9: In a cycle with `acc_valid` low, every rank holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads rank i into way i |
| acc_valid | input | 1 | A way of the set was hit or filled in this cycle |
| acc_way | input | IW = max(1, clog2(WAYS)) | Index of the accessed way |
| repl_req | input | 1 | The controller asks for an eviction candidate |
| victim_valid | output | 1 | Victim index is being supplied for a replace request |
| victim_way | output | IW | Index of the least recently used way |

## Verification
The stimulus starts with a sweep that touches every way once in index order. This separates correct promotion from a design that only swaps neighbours. Accesses to a middle-ranked way and to the oldest way follow; they show whether the decrement is limited to ranks strictly above the old value. Repeated hits on the newest way, and idle cycles with and without replace requests, check that nothing moves when nothing should. A long pseudo-random access stream mixed with same-cycle access and replace pairs is compared step by step against a reference order model. A reset in the middle of the run confirms that the initial ordering is restored.

// File: rtl/lru_rank_pkg.sv
package lru_rank_pkg;

    // Default associativity of one tracked set
    localparam int unsigned LRU_DEF_WAYS = 4;

    // Width of an index or rank for n ways; never below one bit
    function automatic int unsigned lru_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_rank_cell.sv
// Next-rank logic of one way: promote on own access, step down if ranked
// above the accessed way's old rank, otherwise hold.
module lru_rank_cell #(
    parameter int unsigned WAYS     = lru_rank_pkg::LRU_DEF_WAYS,
    parameter int unsigned RW       = lru_rank_pkg::lru_idx_w(WAYS),
    parameter int unsigned THIS_WAY = 0
) (
    input  logic          acc_ok,
    input  logic          acc_sel,
    input  logic [RW-1:0] old_rank,
    input  logic [RW-1:0] rank_q,
    output logic [RW-1:0] rank_d
);
    localparam logic [RW-1:0] TOP_RANK = RW'(WAYS - 1);

    always_comb begin
        rank_d = rank_q;
        if (acc_ok) begin
            if (acc_sel) begin
                rank_d = TOP_RANK;
            end else if (rank_q > old_rank) begin
                rank_d = rank_q - RW'(1);
            end
        end
    end
endmodule

// File: rtl/lru_rank_pick.sv
// Reads the current rank of the accessed way (the value before the update).
module lru_rank_pick #(
    parameter int unsigned WAYS = lru_rank_pkg::LRU_DEF_WAYS,
    parameter int unsigned RW   = lru_rank_pkg::lru_idx_w(WAYS),
    parameter int unsigned IW   = lru_rank_pkg::lru_idx_w(WAYS)
) (
    input  logic [WAYS-1:0][RW-1:0] ranks,
    input  logic [IW-1:0]           way,
    output logic [RW-1:0]           rank_of_way
);
    always_comb begin
        rank_of_way = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            if (way == IW'(i)) begin
                rank_of_way = ranks[i];
            end
        end
    end
endmodule

// File: rtl/lru_zero_find.sv
// Encodes the index of the way whose rank is zero.
module lru_zero_find #(
    parameter int unsigned WAYS = lru_rank_pkg::LRU_DEF_WAYS,
    parameter int unsigned RW   = lru_rank_pkg::lru_idx_w(WAYS),
    parameter int unsigned IW   = lru_rank_pkg::lru_idx_w(WAYS)
) (
    input  logic [WAYS-1:0][RW-1:0] ranks,
    output logic [IW-1:0]           zero_idx
);
    logic [WAYS-1:0] is_zero;

    for (genvar g = 0; g < int'(WAYS); g++) begin : g_zero
        assign is_zero[g] = (ranks[g] == '0);
    end

    always_comb begin
        zero_idx = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            if (is_zero[i]) begin
                zero_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lru_rank_tracker.sv
// Rank-counter LRU order for one cache set.
module lru_rank_tracker #(
    parameter int unsigned WAYS = lru_rank_pkg::LRU_DEF_WAYS
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  acc_valid,
    input  logic [lru_rank_pkg::lru_idx_w(WAYS)-1:0] acc_way,
    input  logic                                  repl_req,
    output logic                                  victim_valid,
    output logic [lru_rank_pkg::lru_idx_w(WAYS)-1:0] victim_way
);
    import lru_rank_pkg::*;

    localparam int unsigned RW = lru_idx_w(WAYS);
    localparam int unsigned IW = lru_idx_w(WAYS);

    typedef struct packed {
        logic [WAYS-1:0][RW-1:0] rank;
    } lru_state_t;

    lru_state_t state_d, state_q;

    logic                    acc_ok;
    logic [RW-1:0]           old_rank;
    logic [WAYS-1:0][RW-1:0] cell_next;
    logic [WAYS*RW-1:0]      rank_flat;

    // Only indices of existing ways cause an update
    assign acc_ok = acc_valid && ({1'b0, acc_way} < (IW + 1)'(WAYS));

    lru_rank_pick #(.WAYS(WAYS), .RW(RW), .IW(IW)) u_pick (
        .ranks       (state_q.rank),
        .way         (acc_way),
        .rank_of_way (old_rank)
    );

    for (genvar g = 0; g < int'(WAYS); g++) begin : g_cell
        lru_rank_cell #(.WAYS(WAYS), .RW(RW), .THIS_WAY(g)) u_cell (
            .acc_ok   (acc_ok),
            .acc_sel  (acc_way == IW'(g)),
            .old_rank (old_rank),
            .rank_q   (state_q.rank[g]),
            .rank_d   (cell_next[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.rank = cell_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WAYS); i++) begin
                state_q.rank[i] <= RW'(i);
            end
        end else begin
            state_q <= state_d;
        end
    end

    lru_zero_find #(.WAYS(WAYS), .RW(RW), .IW(IW)) u_zero (
        .ranks    (state_q.rank),
        .zero_idx (victim_way)
    );

    assign victim_valid = repl_req;
    assign rank_flat    = state_q.rank;

endmodule

// File: rtl/lru_rank_checker.sv
module lru_rank_checker #(
    parameter int unsigned WAYS = lru_rank_pkg::LRU_DEF_WAYS,
    parameter int unsigned RW   = lru_rank_pkg::lru_idx_w(WAYS),
    parameter int unsigned IW   = lru_rank_pkg::lru_idx_w(WAYS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [IW-1:0]      acc_way,
    input logic [IW-1:0]      victim_way,
    input logic [WAYS*RW-1:0] rank_flat
);
    localparam logic [RW-1:0] TOP_RANK = RW'(WAYS - 1);

    function automatic logic [RW-1:0] rank_of(input logic [IW-1:0] w);
        logic [RW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            if (w == IW'(i)) r = rank_flat[i*RW +: RW];
        end
        return r;
    endfunction

    logic [WAYS-1:0] seen;
    logic [WAYS-1:0] zero_mask;
    logic            acc_seen_q;
    logic [IW-1:0]   acc_way_q;

    always_comb begin
        seen      = '0;
        zero_mask = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            for (int v = 0; v < int'(WAYS); v++) begin
                if (rank_flat[i*RW +: RW] == RW'(v)) seen[v] = 1'b1;
            end
            zero_mask[i] = (rank_flat[i*RW +: RW] == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_seen_q <= 1'b0;
            acc_way_q  <= '0;
        end else begin
            acc_seen_q <= acc_valid && ({1'b0, acc_way} < (IW + 1)'(WAYS));
            acc_way_q  <= acc_way;
        end
    end

    assert_promote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_seen_q |-> rank_of(acc_way_q) == TOP_RANK);

    assert_victim_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rank_of(victim_way) == '0);

    assert_top_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && rank_of(acc_way) == TOP_RANK) |=> $stable(rank_flat));

    assert_permutation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    assert_single_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_mask) == 1);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(rank_flat));

    for (genvar g = 0; g < int'(WAYS); g++) begin : g_way
        assert_below_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_way != IW'(g) && rank_flat[g*RW +: RW] < rank_of(acc_way))
            |=> $stable(rank_flat[g*RW +: RW]));

        assert_above_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_way != IW'(g) && rank_flat[g*RW +: RW] > rank_of(acc_way))
            |=> rank_flat[g*RW +: RW] == $past(rank_flat[g*RW +: RW]) - RW'(1));
    end
endmodule

bind lru_rank_tracker lru_rank_checker #(.WAYS(WAYS)) u_lru_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .rank_flat  (rank_flat)
);

// File: tb/test_lru_rank_tracker.sv
`timescale 1ns/1ps
module test_lru_rank_tracker;
    localparam int WAYS = 4;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_way = '0;
    logic          repl_req = 1'b0;
    logic          victim_valid;
    logic [IW-1:0] victim_way;

    always #10 clk = ~clk;

    lru_rank_tracker #(.WAYS(WAYS)) i_lru_rank_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_way      (acc_way),
        .repl_req     (repl_req),
        .victim_valid (victim_valid),
        .victim_way   (victim_way)
    );

    typedef struct {
        int    exp_victim;
        bit    exp_valid;
        string req;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      sample_ev;
    int        n_cmp  = 0;
    int        n_fail = 0;
    int        model_rank[WAYS];

    function automatic int model_victim();
        for (int i = 0; i < WAYS; i++) if (model_rank[i] == 0) return i;
        return -1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < WAYS; i++) model_rank[i] = i;
    endfunction

    function automatic void model_access(input int w);
        int x;
        x = model_rank[w];
        for (int i = 0; i < WAYS; i++) begin
            if (i == w) model_rank[i] = WAYS - 1;
            else if (model_rank[i] > x) model_rank[i] = model_rank[i] - 1;
        end
    endfunction

    // Driver: apply one cycle of stimulus, queue the expected output for it
    task automatic step(input bit av, input int w, input bit rq, input string req);
        exp_item_t it;
        @(negedge clk);
        acc_valid = av;
        acc_way   = IW'(w);
        repl_req  = rq;
        #1;
        it.exp_victim = model_victim();
        it.exp_valid  = rq;
        it.req        = req;
        sb_q.push_back(it);
        -> sample_ev;
        if (av) model_access(w);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0; repl_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: pop and compare whenever the driver has settled a cycle
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (int'(victim_way) != it.exp_victim || victim_valid != it.exp_valid) begin
                    n_fail++;
                    $display("FAIL %s: victim_way=%0d victim_valid=%0b expected victim_way=%0d victim_valid=%0b",
                             it.req, victim_way, victim_valid, it.exp_victim, it.exp_valid);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        model_reset();
        apply_reset();

        // R1: reset state, victim 0 and order 0..3 oldest first
        step(1'b0, 0, 1'b1, "R1");
        // R2/R1: sweep in index order, victim walks 1,2,3,0
        for (int w = 0; w < WAYS; w++) step(1'b1, w, 1'b0, "R2");
        step(1'b0, 0, 1'b0, "R2");

        // R3: middle-ranked way then oldest way
        apply_reset();
        step(1'b1, 1, 1'b0, "R3");
        step(1'b1, 0, 1'b0, "R3");
        step(1'b1, 2, 1'b0, "R3");
        step(1'b0, 0, 1'b0, "R3");

        // R5: repeated hits on the newest way
        step(1'b1, 2, 1'b0, "R5");
        step(1'b1, 2, 1'b0, "R5");
        step(1'b0, 0, 1'b0, "R5");

        // R8: replace requests alone keep the order
        step(1'b0, 0, 1'b1, "R8");
        step(1'b0, 0, 1'b1, "R8");
        step(1'b0, 0, 1'b0, "R8");

        // R9: idle cycles hold the order
        for (int k = 0; k < 3; k++) step(1'b0, k, 1'b0, "R9");

        // R7: access and replace together show the pre-update victim
        step(1'b1, model_victim(), 1'b1, "R7");
        step(1'b0, 0, 1'b1, "R7");

        // R4/R6: pseudo-random accesses mixed with replace requests
        for (int k = 0; k < 400; k++) begin
            bit av, rq;
            int w;
            seed = seed * 32'd1103515245 + 32'd12345;
            av   = seed[20] | seed[21];
            rq   = seed[25];
            w    = int'(seed[17:16]);
            step(av, w, rq, "R6");
        end
        step(1'b0, 0, 1'b0, "R4");

        // R1: reset in the middle of a run restores the initial order
        step(1'b1, 0, 1'b0, "R1");
        apply_reset();
        step(1'b0, 0, 1'b0, "R1");
        step(1'b1, 0, 1'b0, "R1");
        step(1'b0, 0, 1'b0, "R1");

        @(negedge clk);
        #2;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule